// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of an asynchronous 16-bit parallel NOR flash and turns single requests into the multi-cycle command sequences the device expects. A client presents one of four operations on a small request port: read a word, program a word, erase a block, or read the status register. The sequencer then drives the chip-enable, write-enable, output-enable and reset strobes, the address, and a data bus split into output, output-enable and input. It returns a one-cycle response carrying a data word and an error flag.

Every bus cycle is timed by counters in system clock cycles. The setup before the strobe, the write strobe width, the read strobe width and the hold after the strobe are each a parameter. Commands travel in the low byte of the data bus. A program or erase is followed by status polling until the device reports ready. When the optional ready input is in use, the sequencer first waits for that pin. A running operation can be suspended and resumed by the client. A poll timeout keeps a dead device from hanging the port.

Top module: `nflash_seq`

## Requirements
- R1: While `rst` is high, `fl_rp_n` is low, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high and `fl_dq_oe` is low. After reset is released, `req_ready` is high and `fl_rp_n` goes high.
- R2: Request code 0 (read) writes 0xFF and then performs one read cycle at the request address. `rsp_data` returns the bus value sampled in the last cycle of the output-enable strobe, with `rsp_err` low.
- R3: Request code 1 (program) writes exactly 0x40, then the data word to the request address, then 0x70, then polls with read cycles, then writes 0xFF. The response returns the final status byte in `rsp_data[7:0]`.
- R4: Request code 2 (erase) writes 0x20 and then 0xD0 to the request address, and then follows the same status and 0xFF tail as R3. Every word of the 64K-word block that contains the address reads back as 0xFFFF afterwards. Words in other blocks keep their contents.
- R5: Request code 3 (status) writes 0x70, performs one read cycle, and returns the status byte with `rsp_err` low.
- R6: When the status byte that shows bit 7 set also has any of bits 5:3 set, `rsp_err` is high. The 0xFF write still takes place before the response.
- R7: If the device is not ready within `TMO_CYC` cycles after the operation starts, or after a resume, the sequencer writes 0xFF and responds with `rsp_err` high.
- R8: A `susp_req` pulse while a program or erase is pending writes 0xB0. No further bus cycle follows until `resume_req`, which writes 0xD0. Polling then continues to a normal completion.
- R9: In every write cycle, `fl_ce_n` is low for `T_SETUP` cycles before `fl_we_n` falls. `fl_we_n` stays low for exactly `T_WP` cycles. `fl_ce_n` then stays low for `T_HOLD` more cycles. In a read cycle, `fl_oe_n` stays low for exactly `T_OE` cycles.
- R10: `fl_we_n` and `fl_oe_n` are never low together. `fl_dq_oe` is never high while `fl_oe_n` is low, and `fl_we_n` is low only while `fl_ce_n` is low.
- R11: `fl_addr[0]` is always 0, so the byte addresses 2n and 2n+1 reach the same word.
- R12: With `USE_STS` set, after the second write of a program or erase, no read cycle is issued until the synchronised `fl_sts` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while `req_ready` is high |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 status |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Word to program |
| req_ready | output | 1 | Sequencer idle |
| susp_req | input | 1 | Suspend the pending program or erase |
| resume_req | input | 1 | Resume a suspended operation |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Device error or timeout |
| rsp_data | output | 16 | Read word or final status |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_rp_n | output | 1 | Device reset, active low |
| fl_addr | output | ADDR_W | Address bus, bit 0 held low |
| fl_dq_out | output | 16 | Data driven toward the device |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_dq_in | input | 16 | Data from the device |
| fl_sts | input | 1 | Device ready pin, high when idle |

## Verification
The assertions rely on a few things outside the block. `req_op` is stable while `req_valid` is high. `susp_req` and `resume_req` are single pulses. Every timing parameter is at least one cycle. The bench drives all inputs on the falling clock edge and raises `req_valid` only after it has seen `req_ready`. It sends `susp_req` only after the device model has logged the second write of a program, and `resume_req` only while the sequencer is paused. A behavioural device model captures writes on the rising write strobe, counts down busy time, and drives the ready pin.

// File: rtl/nflash_pkg.sv
package nflash_pkg;

    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_STAT  = 2'd3
    } nf_op_e;

    localparam logic [7:0] CMD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_PROG    = 8'h40;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;

    localparam int READY_BIT = 7;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } nf_phase_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_CMD1,
        SQ_CMD2,
        SQ_WAITRDY,
        SQ_STCMD,
        SQ_POLL,
        SQ_SUSP,
        SQ_PAUSED,
        SQ_RESUME,
        SQ_RESTORE
    } nf_seq_e;

    function automatic logic [7:0] first_cmd(input nf_op_e op);
        case (op)
            OP_PROG:  return CMD_PROG;
            OP_ERASE: return CMD_ERASE;
            OP_STAT:  return CMD_STATUS;
            default:  return CMD_ARRAY;
        endcase
    endfunction

    function automatic logic status_fail(input logic [7:0] s);
        return |s[5:3];
    endfunction

    function automatic logic [DATA_W-1:0] cmd_word(input logic [7:0] c);
        return {{(DATA_W-8){1'b0}}, c};
    endfunction

endpackage

// File: rtl/nflash_buscyc.sv
module nflash_buscyc
    import nflash_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int T_SETUP = 2,
    parameter int T_WP    = 3,
    parameter int T_HOLD  = 1,
    parameter int T_OE    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              go_wr,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [DATA_W-1:0] go_data,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ce_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);

    localparam int T_A  = (T_SETUP > T_WP) ? T_SETUP : T_WP;
    localparam int T_B  = (T_HOLD > T_OE) ? T_HOLD : T_OE;
    localparam int TMAX = (T_A > T_B) ? T_A : T_B;
    localparam int CW   = $clog2(TMAX + 1);

    nf_phase_e       phase;
    logic [CW-1:0]   cnt;
    logic            wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            wr     <= 1'b0;
            addr   <= '0;
            dq_out <= '0;
            done   <= 1'b0;
            rdata  <= '0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: if (go) begin
                    phase  <= PH_SETUP;
                    cnt    <= CW'(T_SETUP - 1);
                    wr     <= go_wr;
                    addr   <= {go_addr[ADDR_W-1:1], 1'b0};
                    dq_out <= go_data;
                end
                PH_SETUP: if (cnt == '0) begin
                    phase <= PH_STROBE;
                    cnt   <= wr ? CW'(T_WP - 1) : CW'(T_OE - 1);
                end else begin
                    cnt <= cnt - CW'(1);
                end
                PH_STROBE: if (cnt == '0) begin
                    phase <= PH_HOLD;
                    cnt   <= CW'(T_HOLD - 1);
                    if (!wr) rdata <= dq_in;
                end else begin
                    cnt <= cnt - CW'(1);
                end
                default: if (cnt == '0) begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            endcase
        end
    end

    assign ce_n  = (phase == PH_IDLE);
    assign we_n  = !((phase == PH_STROBE) && wr);
    assign oe_n  = !((phase == PH_STROBE) && !wr);
    assign dq_oe = wr && (phase != PH_IDLE);

    // width of the current write strobe, for the pulse-width check
    logic [CW:0] we_low_cnt;
    always_ff @(posedge clk) begin
        if (rst)        we_low_cnt <= '0;
        else if (!we_n) we_low_cnt <= we_low_cnt + 1'b1;
        else            we_low_cnt <= '0;
    end

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !oe_n));
    assert_no_contention_R10: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> oe_n);
    assert_we_selected_R10: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !ce_n);
    assert_we_width_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (we_low_cnt == (CW+1)'(T_WP)));
    assert_addr_even_R11: assert property (@(posedge clk) disable iff (rst)
        addr[0] == 1'b0);

endmodule

// File: rtl/nflash_ctrl.sv
module nflash_ctrl
    import nflash_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int TMO_CYC = 4096,
    parameter bit USE_STS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              susp_req,
    input  logic              resume_req,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data,
    output logic              bus_go,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              sts_ready
);

    localparam int TW = $clog2(TMO_CYC + 1);

    nf_seq_e           state;
    nf_op_e            op_r;
    logic [ADDR_W-1:0] addr_r;
    logic [DATA_W-1:0] wdata_r;
    logic              launched;
    logic [TW-1:0]     tmo_cnt;
    logic              tmo_hit;
    logic              susp_pend;
    logic              err_r;
    logic              is_bus;
    logic              waiting;
    nf_seq_e           after_start;

    assign tmo_hit     = (tmo_cnt == TW'(TMO_CYC - 1));
    assign waiting     = (state == SQ_WAITRDY) || (state == SQ_STCMD) || (state == SQ_POLL);
    assign after_start = USE_STS ? SQ_WAITRDY : SQ_STCMD;
    assign req_ready   = (state == SQ_IDLE);

    always_comb begin
        is_bus   = 1'b1;
        bus_wr   = 1'b1;
        bus_addr = addr_r;
        bus_data = '0;
        case (state)
            SQ_CMD1:    bus_data = cmd_word(first_cmd(op_r));
            SQ_CMD2: begin
                if (op_r == OP_READ || op_r == OP_STAT) bus_wr = 1'b0;
                else if (op_r == OP_PROG)               bus_data = wdata_r;
                else                                    bus_data = cmd_word(CMD_CONFIRM);
            end
            SQ_STCMD:   bus_data = cmd_word(CMD_STATUS);
            SQ_POLL:    bus_wr   = 1'b0;
            SQ_SUSP:    bus_data = cmd_word(CMD_SUSPEND);
            SQ_RESUME:  bus_data = cmd_word(CMD_CONFIRM);
            SQ_RESTORE: bus_data = cmd_word(CMD_ARRAY);
            default:    is_bus   = 1'b0;
        endcase
    end

    assign bus_go = is_bus && !launched;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            op_r      <= OP_READ;
            addr_r    <= '0;
            wdata_r   <= '0;
            launched  <= 1'b0;
            tmo_cnt   <= '0;
            susp_pend <= 1'b0;
            err_r     <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (bus_done)    launched <= 1'b0;
            else if (bus_go) launched <= 1'b1;

            if (waiting && !tmo_hit) tmo_cnt <= tmo_cnt + TW'(1);

            if (state == SQ_SUSP || state == SQ_IDLE) susp_pend <= 1'b0;
            else if (susp_req && waiting)             susp_pend <= 1'b1;

            case (state)
                SQ_IDLE: if (req_valid) begin
                    op_r    <= nf_op_e'(req_op);
                    addr_r  <= req_addr;
                    wdata_r <= req_wdata;
                    err_r   <= 1'b0;
                    state   <= SQ_CMD1;
                end
                SQ_CMD1: if (bus_done) state <= SQ_CMD2;
                SQ_CMD2: if (bus_done) begin
                    if (op_r == OP_READ || op_r == OP_STAT) begin
                        rsp_data  <= bus_rdata;
                        rsp_err   <= 1'b0;
                        rsp_valid <= 1'b1;
                        state     <= SQ_IDLE;
                    end else begin
                        tmo_cnt <= '0;
                        state   <= after_start;
                    end
                end
                SQ_WAITRDY: begin
                    if (tmo_hit) begin
                        err_r <= 1'b1;
                        state <= SQ_RESTORE;
                    end else if (susp_pend) begin
                        state <= SQ_SUSP;
                    end else if (sts_ready) begin
                        state <= SQ_STCMD;
                    end
                end
                SQ_STCMD: if (bus_done) state <= SQ_POLL;
                SQ_POLL: if (bus_done) begin
                    if (bus_rdata[READY_BIT]) begin
                        err_r    <= status_fail(bus_rdata[7:0]);
                        rsp_data <= bus_rdata;
                        state    <= SQ_RESTORE;
                    end else if (tmo_hit) begin
                        err_r    <= 1'b1;
                        rsp_data <= bus_rdata;
                        state    <= SQ_RESTORE;
                    end else if (susp_pend) begin
                        state <= SQ_SUSP;
                    end
                end
                SQ_SUSP:   if (bus_done) state <= SQ_PAUSED;
                SQ_PAUSED: if (resume_req) state <= SQ_RESUME;
                SQ_RESUME: if (bus_done) begin
                    tmo_cnt <= '0;
                    state   <= after_start;
                end
                SQ_RESTORE: if (bus_done) begin
                    rsp_err   <= err_r;
                    rsp_valid <= 1'b1;
                    state     <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready);
    assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    assert_pause_entry_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(state == SQ_PAUSED) |-> $past(state == SQ_SUSP));
    assert_paused_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_PAUSED) |-> !bus_done);
    assert_ready_wait_R12: assert property (@(posedge clk) disable iff (rst)
        (USE_STS && state == SQ_STCMD && $past(state == SQ_WAITRDY)) |-> $past(sts_ready));

endmodule

// File: rtl/nflash_seq.sv
module nflash_seq
    import nflash_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int T_SETUP = 2,
    parameter int T_WP    = 3,
    parameter int T_HOLD  = 1,
    parameter int T_OE    = 3,
    parameter int TMO_CYC = 4096,
    parameter bit USE_STS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    output logic              req_ready,
    input  logic              susp_req,
    input  logic              resume_req,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [15:0]       rsp_data,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n,
    output logic              fl_rp_n,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [15:0]       fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [15:0]       fl_dq_in,
    input  logic              fl_sts
);

    logic              bus_go;
    logic              bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_data;
    logic              bus_done;
    logic [DATA_W-1:0] bus_rdata;
    logic              sts_meta;
    logic              sts_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_rp_n  <= 1'b0;
            sts_meta <= 1'b0;
            sts_sync <= 1'b0;
        end else begin
            fl_rp_n  <= 1'b1;
            sts_meta <= fl_sts;
            sts_sync <= sts_meta;
        end
    end

    nflash_ctrl #(
        .ADDR_W (ADDR_W),
        .TMO_CYC(TMO_CYC),
        .USE_STS(USE_STS)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .susp_req  (susp_req),
        .resume_req(resume_req),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_data  (rsp_data),
        .bus_go    (bus_go),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .bus_done  (bus_done),
        .bus_rdata (bus_rdata),
        .sts_ready (sts_sync)
    );

    nflash_buscyc #(
        .ADDR_W (ADDR_W),
        .T_SETUP(T_SETUP),
        .T_WP   (T_WP),
        .T_HOLD (T_HOLD),
        .T_OE   (T_OE)
    ) bus_i (
        .clk    (clk),
        .rst    (rst),
        .go     (bus_go),
        .go_wr  (bus_wr),
        .go_addr(bus_addr),
        .go_data(bus_data),
        .done   (bus_done),
        .rdata  (bus_rdata),
        .ce_n   (fl_ce_n),
        .we_n   (fl_we_n),
        .oe_n   (fl_oe_n),
        .addr   (fl_addr),
        .dq_out (fl_dq_out),
        .dq_oe  (fl_dq_oe),
        .dq_in  (fl_dq_in)
    );

    assert_reset_strobe_R1: assert property (@(posedge clk)
        $past(rst) |-> !fl_rp_n);

endmodule

// File: tb/nflash_seq_tb_top.sv
module nflash_seq_tb_top;

    localparam int ADDR_W = 24;
    localparam int PROG_T = 40;
    localparam int ERAS_T = 80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic              req_valid = 1'b0;
    logic [1:0]        req_op = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [15:0]       req_wdata = '0;
    logic              req_ready;
    logic              susp_req = 1'b0;
    logic              resume_req = 1'b0;
    logic              rsp_valid, rsp_err;
    logic [15:0]       rsp_data;
    logic              fl_ce_n, fl_we_n, fl_oe_n, fl_rp_n, fl_dq_oe;
    logic [ADDR_W-1:0] fl_addr;
    logic [15:0]       fl_dq_out, fl_dq_in;
    logic              fl_sts;

    nflash_seq #(.ADDR_W(ADDR_W), .T_SETUP(2), .T_WP(3), .T_HOLD(1), .T_OE(3),
                 .TMO_CYC(600), .USE_STS(1'b1)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .susp_req(susp_req), .resume_req(resume_req), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_data(rsp_data), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_rp_n(fl_rp_n),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_sts(fl_sts)
    );

    // ---------------- device model ----------------
    logic [15:0] mem [0:127];
    logic [15:0] log_d [0:255];
    int nlog = 0;
    int mode = 0, pend = 0, busy = 0, susp = 0, busy_cnt = 0;
    int stuck = 0, force_err = 0, errbit = 0, oe_falls = 0;
    int prev_we = 1, prev_oe = 1, prev_ce = 1;
    int ce_run = 0, we_run = 0, oe_run = 0, cyc_wr = 0;
    int last_setup = 0, last_we_w = 0, last_oe_w = 0, last_total = 0;
    logic [7:0] sr;

    initial for (int i = 0; i < 128; i++) mem[i] = 16'hFFFF;

    assign sr       = {8'((busy == 0) || (susp != 0)), 1'(susp != 0), 1'b0, 1'(errbit != 0), 4'h0};
    assign fl_sts   = !((busy != 0) && (susp == 0));
    assign fl_dq_in = (!fl_oe_n && !fl_ce_n) ?
                      ((mode != 0) ? {8'h00, sr} : mem[{fl_addr[17], fl_addr[6:1]}]) : 16'h0000;

    always @(negedge clk) begin
        if (!fl_rp_n) begin
            busy = 0; mode = 0; pend = 0; susp = 0;
        end else begin
            if (busy != 0 && susp == 0 && stuck == 0) begin
                busy_cnt--;
                if (busy_cnt == 0) begin busy = 0; errbit = force_err; end
            end
            if (prev_we == 0 && fl_we_n) begin
                log_d[nlog[7:0]] = fl_dq_out;
                nlog++;
                if (busy != 0) begin
                    if (susp == 0 && fl_dq_out[7:0] == 8'hB0) susp = 1;
                    else if (susp != 0 && fl_dq_out[7:0] == 8'hD0) susp = 0;
                end else if (pend == 1) begin
                    mem[{fl_addr[17], fl_addr[6:1]}] = fl_dq_out;
                    busy = 1; busy_cnt = PROG_T; mode = 1; pend = 0; errbit = 0;
                end else if (pend == 2) begin
                    if (fl_dq_out[7:0] == 8'hD0) begin
                        for (int i = 0; i < 64; i++) mem[{fl_addr[17], 6'(i)}] = 16'hFFFF;
                        busy = 1; busy_cnt = ERAS_T; mode = 1;
                    end else mode = 0;
                    pend = 0;
                end else begin
                    case (fl_dq_out[7:0])
                        8'h70:        mode = 1;
                        8'h40, 8'h10: pend = 1;
                        8'h20:        pend = 2;
                        default:      mode = 0;
                    endcase
                end
            end
        end
        // bus timing monitor
        if (!fl_ce_n) begin
            if (prev_we == 1 && !fl_we_n) begin last_setup = ce_run; cyc_wr = 1; end
            ce_run++;
        end else if (prev_ce == 0) begin
            if (cyc_wr != 0) last_total = ce_run;
            cyc_wr = 0; ce_run = 0;
        end
        if (!fl_we_n) we_run++; else if (prev_we == 0) begin last_we_w = we_run; we_run = 0; end
        if (!fl_oe_n) oe_run++; else if (prev_oe == 0) begin last_oe_w = oe_run; oe_run = 0; end
        if (prev_oe == 1 && !fl_oe_n) oe_falls++;
        prev_we = int'(fl_we_n); prev_oe = int'(fl_oe_n); prev_ce = int'(fl_ce_n);
    end

    // ---------------- checking ----------------
    int n_tests = 0, n_fail = 0;

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic [ADDR_W-1:0] a, input logic [15:0] d,
                         output logic [15:0] rd, output logic er);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        rd = rsp_data; er = rsp_err;
    endtask

    task automatic check_log(input int base, input int n, input logic [15:0] e0, input logic [15:0] e1,
                             input logic [15:0] e2, input logic [15:0] e3, input logic [15:0] e4,
                             input logic [15:0] e5, input string tag);
        logic [15:0] exp [0:5];
        exp = '{e0, e1, e2, e3, e4, e5};
        check(nlog - base == n, tag, 32'(nlog - base), 32'(n));
        for (int i = 0; i < n; i++)
            check(log_d[8'(base + i)] == exp[i], tag, 32'(log_d[8'(base + i)]), 32'(exp[i]));
    endtask

    // op, byte address, write data, expected data, expected error
    localparam int NV = 10;
    localparam logic [58:0] VEC [0:NV-1] = '{
        {2'd1, 24'h000010, 16'h1234, 16'h0080, 1'b0},
        {2'd0, 24'h000010, 16'h0000, 16'h1234, 1'b0},
        {2'd1, 24'h000020, 16'hBEEF, 16'h0080, 1'b0},
        {2'd0, 24'h000021, 16'h0000, 16'hBEEF, 1'b0},
        {2'd1, 24'h020010, 16'h5A5A, 16'h0080, 1'b0},
        {2'd0, 24'h000040, 16'h0000, 16'hFFFF, 1'b0},
        {2'd2, 24'h000024, 16'h0000, 16'h0080, 1'b0},
        {2'd0, 24'h000010, 16'h0000, 16'hFFFF, 1'b0},
        {2'd0, 24'h020010, 16'h0000, 16'h5A5A, 1'b0},
        {2'd3, 24'h000000, 16'h0000, 16'h0080, 1'b0}
    };

    initial begin
        logic [15:0] rd;
        logic er;
        int base, falls0;

        // R1 reset state
        repeat (3) @(negedge clk);
        check(fl_rp_n == 1'b0, "R1 rp_n in reset", 32'(fl_rp_n), 32'h0);
        check(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes idle", {29'h0, fl_ce_n, fl_we_n, fl_oe_n}, 32'h7);
        check(fl_dq_oe == 1'b0, "R1 dq not driven", 32'(fl_dq_oe), 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
        check(fl_rp_n == 1'b1, "R1 rp_n released", 32'(fl_rp_n), 32'h1);

        // vector table: R2 read, R3 program, R4 erase scope, R5 status, R11 odd address
        for (int v = 0; v < NV; v++) begin
            do_op(VEC[v][58:57], VEC[v][56:33], VEC[v][32:17], rd, er);
            check(rd == VEC[v][16:1], $sformatf("R2-R5 vector %0d data", v), 32'(rd), 32'(VEC[v][16:1]));
            check(er == VEC[v][0], $sformatf("R2 vector %0d err", v), 32'(er), 32'(VEC[v][0]));
        end

        // R3 program command sequence, then R9 write timing
        base = nlog;
        do_op(2'd1, 24'h000050, 16'hA55A, rd, er);
        check_log(base, 4, 16'h0040, 16'hA55A, 16'h0070, 16'h00FF, 16'h0, 16'h0, "R3 program sequence");
        check(last_setup == 2, "R9 setup cycles", 32'(last_setup), 32'd2);
        check(last_we_w == 3, "R9 write strobe width", 32'(last_we_w), 32'd3);
        check(last_total == 6, "R9 write cycle select length", 32'(last_total), 32'd6);

        // R4 erase command sequence
        base = nlog;
        do_op(2'd2, 24'h020000, 16'h0000, rd, er);
        check_log(base, 4, 16'h0020, 16'h00D0, 16'h0070, 16'h00FF, 16'h0, 16'h0, "R4 erase sequence");
        do_op(2'd0, 24'h020010, 16'h0000, rd, er);
        check(rd == 16'hFFFF, "R4 block erased", 32'(rd), 32'hFFFF);
        check(last_oe_w == 3, "R9 read strobe width", 32'(last_oe_w), 32'd3);

        // R2 read sequence writes FF first
        base = nlog;
        do_op(2'd0, 24'h000050, 16'h0000, rd, er);
        check_log(base, 1, 16'h00FF, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, "R2 read sequence");
        check(rd == 16'hA55A, "R2 read data", 32'(rd), 32'hA55A);

        // R6 device error bits
        force_err = 1;
        base = nlog;
        do_op(2'd1, 24'h000060, 16'h0F0F, rd, er);
        force_err = 0;
        check(er == 1'b1, "R6 error flagged", 32'(er), 32'h1);
        check(rd[7:0] == 8'h90, "R6 status returned", 32'(rd[7:0]), 32'h90);
        check(log_d[8'(nlog - 1)] == 16'h00FF, "R6 restore write", 32'(log_d[8'(nlog - 1)]), 32'hFF);

        // R8 suspend and resume
        base = nlog;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_addr = 24'h000070; req_wdata = 16'hC3C3;
        @(negedge clk);
        req_valid = 1'b0;
        for (int g = 0; g < 200 && nlog - base < 2; g++) @(negedge clk);
        repeat (2) @(negedge clk);
        susp_req = 1'b1;
        @(negedge clk);
        susp_req = 1'b0;
        for (int g = 0; g < 200 && nlog - base < 3; g++) @(negedge clk);
        falls0 = oe_falls;
        repeat (60) @(negedge clk);
        check(busy == 1, "R8 device held busy while suspended", 32'(busy), 32'h1);
        check(oe_falls == falls0, "R8 no bus cycle while paused", 32'(oe_falls - falls0), 32'h0);
        check(nlog - base == 3, "R8 no write while paused", 32'(nlog - base), 32'd3);
        resume_req = 1'b1;
        @(negedge clk);
        resume_req = 1'b0;
        for (int g = 0; g < 2000 && !rsp_valid; g++) @(negedge clk);
        check(rsp_err == 1'b0, "R8 completes cleanly", 32'(rsp_err), 32'h0);
        check_log(base, 6, 16'h0040, 16'hC3C3, 16'h00B0, 16'h00D0, 16'h0070, 16'h00FF, "R8 suspend sequence");
        do_op(2'd0, 24'h000070, 16'h0000, rd, er);
        check(rd == 16'hC3C3, "R8 data programmed", 32'(rd), 32'hC3C3);

        // R7 timeout and R12 no polling while ready pin low
        stuck = 1;
        falls0 = oe_falls;
        do_op(2'd2, 24'h000000, 16'h0000, rd, er);
        check(er == 1'b1, "R7 timeout error", 32'(er), 32'h1);
        check(oe_falls == falls0, "R12 no status read while not ready", 32'(oe_falls - falls0), 32'h0);
        check(log_d[8'(nlog - 1)] == 16'h00FF, "R7 restore write", 32'(log_d[8'(nlog - 1)]), 32'hFF);

        // R1 reset mid-life clears the device through rp_n
        stuck = 0;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check(fl_rp_n == 1'b0, "R1 rp_n asserted on reset", 32'(fl_rp_n), 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(req_ready == 1'b1 && busy == 0, "R1 idle after reset", 32'(req_ready), 32'h1);
        do_op(2'd3, 24'h000000, 16'h0000, rd, er);
        check(rd == 16'h0080, "R5 status after reset", 32'(rd), 32'h0080);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule